// File: doc/BRIEF.md
# Dynamic shift and rotate unit

This block is the shift stage of a 32-bit integer pipeline. Each cycle it can accept one operation: an operation code, a data operand, a signed shift-count operand and the current T flag (the one-bit carry/test flag of the core). It produces a shifted or rotated result and the updated T flag.

Two dynamic shifts take their distance and direction from the count operand. A non-negative count shifts left by its low five bits. A negative count shifts right. The single-bit operations move the outgoing bit into T. The rotates through T also feed the old T back in. The fixed shifts move by 2, 8 or 16 places and leave T alone.

The result and flag are captured in an output register whenever the input is marked valid. A matching valid output follows one clock edge later. The register holds its value while no new operation arrives.

Top module: `dyn_shift_unit`

## Requirements
- R1: Codes 0 (arithmetic dynamic) and 1 (logical dynamic), with count bit 31 clear, shift the operand left by count[4:0] with zero fill. Count bits 30..5 are ignored.
- R2: With count bit 31 set and count[4:0] nonzero, codes 0 and 1 shift right by 32 minus count[4:0] places. Code 0 fills with the operand's bit 31; code 1 fills with zeros.
- R3: With count bit 31 set and count[4:0] zero, code 0 returns 32 copies of the operand's bit 31 and code 1 returns zero.
- R4: Codes 0 and 1 return the incoming T flag unchanged.
- R5: Code 2 (shift left one, zero into bit 0) and code 5 (rotate left one, old bit 31 into bit 0) set T to the operand's bit 31.
- R6: Each of the following codes sets T to the operand's bit 0:
  - code 3, logical right one, zero into bit 31;
  - code 4, arithmetic right one, bit 31 kept;
  - code 6, rotate right one, old bit 0 into bit 31.
- R7: Code 7 rotates left through T: old T goes into bit 0 and the new T is the old bit 31. Code 8 rotates right through T: old T goes into bit 31 and the new T is the old bit 0.
- R8: Codes 9/10 shift left/right by 2, codes 11/12 by 8 and codes 13/14 by 16, all with zero fill. Each returns T unchanged.
- R9: Code 15 returns the operand and T unchanged.
- R10: On a rising edge with in_valid high, result and t_out take the new values and out_valid goes high. On an edge with in_valid low, out_valid goes low and result and t_out hold.
- R11: An active-low synchronous reset clears result, t_out and out_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 4 | Operation code (see requirements) |
| operand | input | 32 | Data to shift or rotate |
| count | input | 32 | Signed shift count for codes 0 and 1 |
| t_in | input | 1 | Current T flag |
| result | output | 32 | Registered result |
| t_out | output | 1 | Registered updated T flag |
| out_valid | output | 1 | Result register loaded on the last edge |

## Verification
The bench targets the negative counts whose low five bits are zero. A design that fed those bits straight into the right-shift amount would shift by 32 modulo 32 and return the operand untouched, where all-sign or all-zero is required. Counts of -1 and 33 check that the right distance is 32 minus the low bits and that the upper count bits are ignored. Where a single-bit op selects the wrong end for T, or a rotate-through-T and a plain rotate are swapped, the returned flag or the refilled end bit comes out wrong. The bench also checks that the result register holds through an idle cycle and clears on reset.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [3:0] {
    OP_DYN_ARI = 4'd0,
    OP_DYN_LOG = 4'd1,
    OP_SHL1    = 4'd2,
    OP_SHR1    = 4'd3,
    OP_SAR1    = 4'd4,
    OP_ROL1    = 4'd5,
    OP_ROR1    = 4'd6,
    OP_ROLT    = 4'd7,
    OP_RORT    = 4'd8,
    OP_SL2     = 4'd9,
    OP_SR2     = 4'd10,
    OP_SL8     = 4'd11,
    OP_SR8     = 4'd12,
    OP_SL16    = 4'd13,
    OP_SR16    = 4'd14,
    OP_PASS    = 4'd15
  } op_e;

  localparam int NUM_FIXED = 3;

  function automatic int fixed_amt(input int idx);
    case (idx)
      0:       return 2;
      1:       return 8;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/shift_dyn.sv
module shift_dyn #(
  parameter int W = 32,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic          neg,
  input  logic [CW-1:0] lo,
  input  logic          arith,
  output logic [W-1:0]  res,
  output logic          neg_zero_case
);
  // Right distance for a negative count: W minus the low count bits.
  function automatic logic [W-1:0] dyn_calc(input logic [W-1:0] v,
                                            input logic          n,
                                            input logic [CW-1:0] l,
                                            input logic          ar);
    logic [CW:0] ramt;
    ramt = (CW+1)'(W) - {1'b0, l};
    if (!n)
      return v << l;
    else if (l == '0)
      return ar ? {W{v[W-1]}} : '0;
    else if (ar)
      return W'($signed(v) >>> ramt);
    else
      return v >> ramt;
  endfunction

  assign neg_zero_case = neg && (lo == '0);
  assign res = dyn_calc(a, neg, lo, arith);
endmodule

// File: rtl/shift_single.sv
module shift_single
  import shift_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic         t_in,
  output logic [W-1:0] res,
  output logic         t_res
);
  always_comb begin
    res   = a;
    t_res = t_in;
    case (op)
      OP_SHL1: begin res = {a[W-2:0], 1'b0};    t_res = a[W-1]; end
      OP_SHR1: begin res = {1'b0, a[W-1:1]};    t_res = a[0];   end
      OP_SAR1: begin res = {a[W-1], a[W-1:1]};  t_res = a[0];   end
      OP_ROL1: begin res = {a[W-2:0], a[W-1]};  t_res = a[W-1]; end
      OP_ROR1: begin res = {a[0], a[W-1:1]};    t_res = a[0];   end
      OP_ROLT: begin res = {a[W-2:0], t_in};    t_res = a[W-1]; end
      OP_RORT: begin res = {t_in, a[W-1:1]};    t_res = a[0];   end
      default: ;
    endcase
  end

  // R6
  always_comb begin
    if (op == OP_SAR1) begin
      sar_sign_chk: assert (res[W-1] == a[W-1]);
    end
  end
endmodule

// File: rtl/shift_fixed.sv
module shift_fixed #(
  parameter int W   = 32,
  parameter int AMT = 2
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] left_res,
  output logic [W-1:0] right_res
);
  assign left_res  = a << AMT;
  assign right_res = a >> AMT;
endmodule

// File: rtl/dyn_shift_unit.sv
module dyn_shift_unit
  import shift_pkg::*;
#(
  parameter int W = 32,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] count,
  input  logic         t_in,
  output logic [W-1:0] result,
  output logic         t_out,
  output logic         out_valid
);
  op_e op;
  assign op = op_e'(op_sel);

  logic unused_cnt_hi;
  assign unused_cnt_hi = ^count[W-2:CW];

  logic         is_dyn;
  logic [W-1:0] dyn_res;
  logic         neg_zero_case;
  assign is_dyn = (op == OP_DYN_ARI) || (op == OP_DYN_LOG);

  shift_dyn #(.W(W)) u_dyn (
    .a(operand), .neg(count[W-1]), .lo(count[CW-1:0]),
    .arith(op == OP_DYN_ARI), .res(dyn_res), .neg_zero_case(neg_zero_case)
  );

  logic [W-1:0] one_res;
  logic         one_t;
  shift_single #(.W(W)) u_single (
    .op(op), .a(operand), .t_in(t_in), .res(one_res), .t_res(one_t)
  );

  logic [W-1:0] fx_l [NUM_FIXED];
  logic [W-1:0] fx_r [NUM_FIXED];
  for (genvar g = 0; g < NUM_FIXED; g++) begin : g_fixed
    shift_fixed #(.W(W), .AMT(fixed_amt(g))) u_fx (
      .a(operand), .left_res(fx_l[g]), .right_res(fx_r[g])
    );
  end

  logic [W-1:0] nxt_res;
  logic         nxt_t;
  always_comb begin
    nxt_res = operand;
    nxt_t   = t_in;
    case (op)
      OP_DYN_ARI, OP_DYN_LOG: nxt_res = dyn_res;
      OP_SHL1, OP_SHR1, OP_SAR1, OP_ROL1, OP_ROR1, OP_ROLT, OP_RORT: begin
        nxt_res = one_res;
        nxt_t   = one_t;
      end
      OP_SL2:  nxt_res = fx_l[0];
      OP_SR2:  nxt_res = fx_r[0];
      OP_SL8:  nxt_res = fx_l[1];
      OP_SR8:  nxt_res = fx_r[1];
      OP_SL16: nxt_res = fx_l[2];
      OP_SR16: nxt_res = fx_r[2];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      t_out     <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        t_out  <= nxt_t;
      end
    end
  end

  // R4
  dyn_t_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_dyn) |=> (t_out == $past(t_in)));

  // R3
  dyn_neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_DYN_LOG && neg_zero_case) |=> (result == '0));

  // R8
  fixed_t_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op >= OP_SL2 && op <= OP_SR16) |=> (t_out == $past(t_in)));

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(t_out)));
endmodule

// File: tb/test_dyn_shift_unit.sv
module test_dyn_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op_sel;
  logic [31:0] operand;
  logic [31:0] count;
  logic        t_in;
  logic [31:0] result;
  logic        t_out;
  logic        out_valid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  dyn_shift_unit i_dyn_shift_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .operand(operand), .count(count), .t_in(t_in),
    .result(result), .t_out(t_out), .out_valid(out_valid)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] c;
    logic        t;
    logic [31:0] er;
    logic        et;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  32'h0000_00F0, 32'h0000_0004, 1'b1, 32'h0000_0F00, 1'b1, 8'd1}, // R1
    '{4'd0,  32'h8000_0000, 32'hFFFF_FFFC, 1'b0, 32'hF800_0000, 1'b0, 8'd2}, // R2
    '{4'd1,  32'h8000_0000, 32'hFFFF_FFFC, 1'b1, 32'h0800_0000, 1'b1, 8'd2}, // R2 R4
    '{4'd0,  32'h8000_1234, 32'h8000_0000, 1'b1, 32'hFFFF_FFFF, 1'b1, 8'd3}, // R3
    '{4'd1,  32'h8000_1234, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b0, 8'd3}, // R3
    '{4'd0,  32'h7000_0000, 32'hFFFF_FFE0, 1'b1, 32'h0000_0000, 1'b1, 8'd3}, // R3
    '{4'd1,  32'h8000_0002, 32'hFFFF_FFFF, 1'b0, 32'h4000_0001, 1'b0, 8'd2}, // R2
    '{4'd0,  32'h4000_0001, 32'h0000_0021, 1'b0, 32'h8000_0002, 1'b0, 8'd1}, // R1
    '{4'd2,  32'h8000_0001, 32'h0,         1'b0, 32'h0000_0002, 1'b1, 8'd5}, // R5
    '{4'd3,  32'h8000_0001, 32'h0,         1'b0, 32'h4000_0000, 1'b1, 8'd6}, // R6
    '{4'd4,  32'h8000_0002, 32'h0,         1'b1, 32'hC000_0001, 1'b0, 8'd6}, // R6
    '{4'd5,  32'h8000_0002, 32'h0,         1'b0, 32'h0000_0005, 1'b1, 8'd5}, // R5
    '{4'd6,  32'h0000_0003, 32'h0,         1'b0, 32'h8000_0001, 1'b1, 8'd6}, // R6
    '{4'd7,  32'h4000_0000, 32'h0,         1'b1, 32'h8000_0001, 1'b0, 8'd7}, // R7
    '{4'd8,  32'h0000_0002, 32'h0,         1'b1, 32'h8000_0001, 1'b0, 8'd7}, // R7
    '{4'd9,  32'hC000_0003, 32'h0,         1'b1, 32'h0000_000C, 1'b1, 8'd8}, // R8
    '{4'd10, 32'hC000_0003, 32'h0,         1'b0, 32'h3000_0000, 1'b0, 8'd8}, // R8
    '{4'd11, 32'h1234_5678, 32'h0,         1'b1, 32'h3456_7800, 1'b1, 8'd8}, // R8
    '{4'd12, 32'h1234_5678, 32'h0,         1'b0, 32'h0012_3456, 1'b0, 8'd8}, // R8
    '{4'd13, 32'h1234_5678, 32'h0,         1'b1, 32'h5678_0000, 1'b1, 8'd8}, // R8
    '{4'd14, 32'h8765_4321, 32'h0,         1'b0, 32'h0000_8765, 1'b0, 8'd8}, // R8
    '{4'd15, 32'hDEAD_BEEF, 32'h1,         1'b1, 32'hDEAD_BEEF, 1'b1, 8'd9}  // R9
  };

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] a,
                       input logic [31:0] c, input logic t);
    @(negedge clk);
    in_valid = 1'b1; op_sel = o; operand = a; count = c; t_in = t;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_sel = '0; operand = '0; count = '0; t_in = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check32("R11", result, 32'h0);
    check32("R11", {31'b0, t_out}, 32'h0);
    check32("R11", {31'b0, out_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].c, VECS[i].t);
      check32($sformatf("R%0d result", VECS[i].req), result, VECS[i].er);
      check32($sformatf("R%0d t", VECS[i].req), {31'b0, t_out}, {31'b0, VECS[i].et});
    end
    check32("R10 valid", {31'b0, out_valid}, 32'h1);

    // R10 idle cycle: valid drops, result and T hold, new inputs ignored
    @(negedge clk);
    in_valid = 1'b0; op_sel = 4'd9; operand = 32'h1111_1111; t_in = 1'b0;
    @(posedge clk);
    #1;
    check32("R10 idle valid", {31'b0, out_valid}, 32'h0);
    check32("R10 idle hold", result, 32'hDEAD_BEEF);
    check32("R10 idle t", {31'b0, t_out}, 32'h1);

    // R4 dynamic op with T=0 after T=1 held
    apply(4'd1, 32'h0000_0001, 32'h0000_001F, 1'b0);
    check32("R1 shift 31", result, 32'h8000_0000);
    check32("R4 t", {31'b0, t_out}, 32'h0);

    // R11 reset after activity
    apply(4'd15, 32'hFFFF_FFFF, 32'h0, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check32("R11 result", result, 32'h0);
    check32("R11 t", {31'b0, t_out}, 32'h0);
    check32("R11 valid", {31'b0, out_valid}, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule